// File: doc/BRIEF.md
# Synchronous Serial Port Register and FIFO Block

This block is the software-facing side of a synchronous serial port. A processor reaches it through a simple word-addressed register bus with one write strobe and one read strobe. Through that bus it sets the frame size, stores a clock divider value and an interrupt mask, pushes words for transmission and pulls received words. Two 8-entry, 16-bit queues sit between the bus and a separate shift engine. The engine drains the transmit queue through a valid/ready pop port and fills the receive queue through a valid/ready push port.

Queue state drives a status word, a raw interrupt word and a masked interrupt word. Their OR drives a single level-sensitive interrupt line. All flags are combinational functions of the queue fill counts, so they change in the same cycle as the push or pop that caused them. Read data is combinational from the address. A data-register read pops the receive queue at the clock edge that ends the read cycle.

Top module: `ssp_ctrl_regs`

## Requirements
- R1: After reset both queues are empty and the mask is 0. Status (offset 0x0C) reads 0x03, raw interrupts (0x18) read 0x08, masked interrupts (0x1C) read 0, `irq_o` is low, `tx_pop_valid` is low and `rx_push_ready` is high.
- R2: A write to the data register (0x08) appends `wdata` ANDed with the frame-size mask to the transmit queue if it holds fewer than 8 words. When the queue is full, the write is dropped.
- R3: A read of the data register returns the oldest receive word and removes it at that clock edge. When the receive queue is empty, the read returns 0 and changes no state.
- R4: Status bits are: bit0 transmit queue empty, bit1 transmit queue not full, bit2 receive queue not empty, bit3 receive queue full (8 words), bit4 busy (transmit queue not empty). All other bits read 0.
- R5: Raw interrupt bit2 is set while the receive queue holds 4 or more words. Raw bit3 is set while the transmit queue holds 4 or fewer words. Bits 1:0 read 0.
- R6: The mask register (0x14, 4 bits) reads back as written. The masked word (0x1C) is raw AND mask. `irq_o` is high exactly when the masked word is nonzero.
- R7: The frame-size mask is (1 << (n+1)) - 1, where n is control-0 bits [3:0]. This gives frame sizes of 1 to 16 bits. Control 0 (0x00) keeps 16 bits and control 1 (0x04) keeps 4 bits, both read back as stored.
- R8: The divider register (0x10) keeps only bits [7:0]. The DMA register (0x20) and any undefined offset read 0.
- R9: Offsets 0xFE0 to 0xFFC each return one identification byte in bits [7:0], in word order: 0x5A, 0x3C, 0x81, 0x07, 0xE4, 0x19, 0xC2, 0x6B.
- R10: `tx_pop_valid` is high while the transmit queue is not empty, and `tx_pop_data` shows its oldest word. A cycle with valid and `tx_pop_ready` both high removes that word.
- R11: `rx_push_ready` is high while the receive queue is not full. A cycle with `rx_push_valid` high and ready high appends `rx_push_data` ANDed with the frame-size mask. A push into a full queue is ignored.
- R12: Both queues deliver words in arrival order, including after their pointers wrap past the last entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive queue on the data offset) |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Level interrupt |
| tx_pop_valid | output | 1 | Transmit queue has a word |
| tx_pop_data | output | 16 | Oldest transmit word |
| tx_pop_ready | input | 1 | Engine takes the transmit word |
| rx_push_valid | input | 1 | Engine offers a received word |
| rx_push_data | input | 16 | Received word |
| rx_push_ready | output | 1 | Receive queue has room |

## Verification
The hardest states to reach are those where the queues sit at their limits while the pointers have already wrapped. Examples are a full receive queue refusing one more push, and a full transmit queue dropping a bus write while the earlier words must still come out in order. The stimulus first moves a few words through each queue so the pointers start mid-array. It then fills the queue to 8 through the ports and offers a ninth word. Draining all 8 then shows whether the dropped word leaked in or the order broke. The interrupt thresholds are reached by holding the two queues at different fill levels under different masks.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int FIFO_DEPTH = 8;
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 12;
    localparam int BUS_W      = 32;
    localparam int RX_LEVEL   = 4;
    localparam int TX_LEVEL   = 4;

    localparam logic [ADDR_W-1:0] OFS_CTRL0  = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_CTRL1  = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_DATA   = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_DIV    = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_MASKED = 12'h01C;
    localparam logic [ADDR_W-1:0] OFS_DMA    = 12'h020;

    // Status word, packed so that busy lands in bit 4 and tx_empty in bit 0.
    typedef struct packed {
        logic busy;
        logic rx_full;
        logic rx_nempty;
        logic tx_nfull;
        logic tx_empty;
    } ssp_status_t;

    // Interrupt word: bit3 transmit level, bit2 receive level, bits 1:0 unused.
    typedef struct packed {
        logic tx_lvl;
        logic rx_lvl;
        logic [1:0] rsvd;
    } ssp_irq_t;

    function automatic logic [DATA_W-1:0] size_mask(input logic [3:0] sel);
        return {DATA_W{1'b1}} >> (4'd15 - sel);
    endfunction

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    return 8'h5A;
            3'd1:    return 8'h3C;
            3'd2:    return 8'h81;
            3'd3:    return 8'h07;
            3'd4:    return 8'hE4;
            3'd5:    return 8'h19;
            3'd6:    return 8'hC2;
            default: return 8'h6B;
        endcase
    endfunction

endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_push;
    logic             do_pop;

    assign do_push = push && (count != CNT_W'(DEPTH));
    assign do_pop  = pop && (count != '0);
    assign head    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= next_ptr(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= next_ptr(rd_ptr);
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/ssp_flags.sv
module ssp_flags
    import ssp_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int RX_LVL   = 4,
    parameter int TX_LVL   = 4,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [3:0]       mask,
    output ssp_status_t      status,
    output ssp_irq_t         raw,
    output logic [3:0]       masked,
    output logic             irq
);

    always_comb begin
        status.tx_empty  = (tx_count == '0);
        status.tx_nfull  = (tx_count != CNT_W'(DEPTH));
        status.rx_nempty = (rx_count != '0);
        status.rx_full   = (rx_count == CNT_W'(DEPTH));
        status.busy      = (tx_count != '0);

        raw.rsvd   = 2'b00;
        raw.rx_lvl = (rx_count >= CNT_W'(RX_LVL));
        raw.tx_lvl = (tx_count <= CNT_W'(TX_LVL));

        masked = raw & mask;
        irq    = |masked;
    end

endmodule

// File: rtl/ssp_ctrl_regs.sv
module ssp_ctrl_regs
    import ssp_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq_o,
    output logic              tx_pop_valid,
    output logic [DATA_W-1:0] tx_pop_data,
    input  logic              tx_pop_ready,
    input  logic              rx_push_valid,
    input  logic [DATA_W-1:0] rx_push_data,
    output logic              rx_push_ready
);

    logic [15:0]       ctrl0_q;
    logic [3:0]        ctrl1_q;
    logic [7:0]        div_q;
    logic [3:0]        mask_q;
    logic [DATA_W-1:0] fmask;
    logic [CNT_W-1:0]  tx_count;
    logic [CNT_W-1:0]  rx_count;
    logic [DATA_W-1:0] rx_head;
    logic              tx_push;
    logic              rx_pop;
    ssp_status_t       status;
    ssp_irq_t          raw;
    logic [3:0]        masked;

    assign fmask   = size_mask(ctrl0_q[3:0]);
    assign tx_push = bus_wr && (bus_addr == OFS_DATA);
    assign rx_pop  = bus_rd && (bus_addr == OFS_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl0_q <= '0;
            ctrl1_q <= '0;
            div_q   <= '0;
            mask_q  <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_CTRL0: ctrl0_q <= bus_wdata[15:0];
                OFS_CTRL1: ctrl1_q <= bus_wdata[3:0];
                OFS_DIV:   div_q   <= bus_wdata[7:0];
                OFS_MASK:  mask_q  <= bus_wdata[3:0];
                default:   ;
            endcase
        end
    end

    ssp_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) tx_fifo_i (
        .clk       (clk),
        .rst       (rst),
        .push      (tx_push),
        .push_data (bus_wdata[DATA_W-1:0] & fmask),
        .pop       (tx_pop_ready),
        .head      (tx_pop_data),
        .count     (tx_count)
    );

    ssp_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) rx_fifo_i (
        .clk       (clk),
        .rst       (rst),
        .push      (rx_push_valid),
        .push_data (rx_push_data & fmask),
        .pop       (rx_pop),
        .head      (rx_head),
        .count     (rx_count)
    );

    ssp_flags #(.DEPTH(DEPTH), .RX_LVL(RX_LEVEL), .TX_LVL(TX_LEVEL)) flags_i (
        .tx_count (tx_count),
        .rx_count (rx_count),
        .mask     (mask_q),
        .status   (status),
        .raw      (raw),
        .masked   (masked),
        .irq      (irq_o)
    );

    assign tx_pop_valid  = !status.tx_empty;
    assign rx_push_ready = !status.rx_full;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[11:5] == 7'h7F) begin
            bus_rdata[7:0] = id_byte(bus_addr[4:2]);
        end else begin
            case (bus_addr)
                OFS_CTRL0:  bus_rdata[15:0] = ctrl0_q;
                OFS_CTRL1:  bus_rdata[3:0]  = ctrl1_q;
                OFS_DATA:   bus_rdata[DATA_W-1:0] = status.rx_nempty ? rx_head : '0;
                OFS_STATUS: bus_rdata[4:0]  = status;
                OFS_DIV:    bus_rdata[7:0]  = div_q;
                OFS_MASK:   bus_rdata[3:0]  = mask_q;
                OFS_RAW:    bus_rdata[3:0]  = raw;
                OFS_MASKED: bus_rdata[3:0]  = masked;
                default:    bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/ssp_ctrl_regs_chk.sv
module ssp_ctrl_regs_chk
    import ssp_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              rx_push_valid,
    input logic [CNT_W-1:0]  tx_count,
    input logic [CNT_W-1:0]  rx_count,
    input logic [3:0]        mask_q,
    input logic              irq_o,
    input logic              tx_pop_valid,
    input logic              rx_push_ready
);

    a_r10_valid_tracks_count: assert property (@(posedge clk) disable iff (rst)
        tx_pop_valid == (tx_count != '0));

    a_r11_ready_tracks_room: assert property (@(posedge clk) disable iff (rst)
        rx_push_ready == (rx_count != CNT_W'(DEPTH)));

    a_r5_rx_level_irq: assert property (@(posedge clk) disable iff (rst)
        (rx_count >= CNT_W'(RX_LEVEL) && mask_q[2]) |-> irq_o);

    a_r6_quiet_when_masked: assert property (@(posedge clk) disable iff (rst)
        (mask_q == 4'd0) |-> !irq_o);

    a_r3_empty_read_no_change: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFS_DATA && rx_count == '0 && !rx_push_valid)
        |=> (rx_count == '0));

    a_r2_tx_no_overflow: assert property (@(posedge clk) disable iff (rst)
        tx_count <= CNT_W'(DEPTH));

    a_r12_tx_single_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (int'(tx_count) <= int'($past(tx_count)) + 1
                  && int'(tx_count) + 1 >= int'($past(tx_count))));

endmodule

bind ssp_ctrl_regs ssp_ctrl_regs_chk #(.DEPTH(DEPTH)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .bus_rd        (bus_rd),
    .bus_addr      (bus_addr),
    .rx_push_valid (rx_push_valid),
    .tx_count      (tx_count),
    .rx_count      (rx_count),
    .mask_q        (mask_q),
    .irq_o         (irq_o),
    .tx_pop_valid  (tx_pop_valid),
    .rx_push_ready (rx_push_ready)
);

// File: tb/ssp_ctrl_regs_tb.sv
module ssp_ctrl_regs_tb_top;
    import ssp_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        tx_pop_valid;
    logic [15:0] tx_pop_data;
    logic        tx_pop_ready = 1'b0;
    logic        rx_push_valid = 1'b0;
    logic [15:0] rx_push_data = '0;
    logic        rx_push_ready;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ssp_ctrl_regs dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .tx_pop_valid(tx_pop_valid), .tx_pop_data(tx_pop_data),
        .tx_pop_ready(tx_pop_ready), .rx_push_valid(rx_push_valid),
        .rx_push_data(rx_push_data), .rx_push_ready(rx_push_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Value of a register as seen during a read cycle; the read completes at the next edge.
    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic eng_pop_chk(input string req, input logic [15:0] exp);
        @(negedge clk);
        chk(req, {31'd0, tx_pop_valid}, 32'd1);
        chk(req, {16'd0, tx_pop_data}, {16'd0, exp});
        tx_pop_ready = 1'b1;
        @(negedge clk);
        tx_pop_ready = 1'b0;
    endtask

    task automatic eng_push(input logic [15:0] d);
        @(negedge clk);
        rx_push_valid = 1'b1; rx_push_data = d;
        @(negedge clk);
        rx_push_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 irq", {31'd0, irq_o}, 32'd0);
        chk("R1 tx_valid", {31'd0, tx_pop_valid}, 32'd0);
        chk("R1 rx_ready", {31'd0, rx_push_ready}, 32'd1);
        rd_chk("R1 status", OFS_STATUS, 32'h03);
        rd_chk("R1 raw", OFS_RAW, 32'h08);
        rd_chk("R1 masked", OFS_MASKED, 32'h00);
        rd_chk("R1 mask", OFS_MASK, 32'h00);
    endtask

    task automatic t_tx_path();
        wr(OFS_CTRL0, 32'h7);
        for (int i = 0; i < 3; i++) wr(OFS_DATA, 32'h200 + i);
        rd_chk("R4 status three tx", OFS_STATUS, 32'h12);
        for (int i = 0; i < 3; i++) eng_pop_chk("R10 pop warmup", 16'(i));
        for (int i = 0; i < 8; i++) wr(OFS_DATA, 32'h100 + 32'(i) * 32'h11);
        rd_chk("R4 status tx full", OFS_STATUS, 32'h10);
        rd_chk("R5 raw tx eight", OFS_RAW, 32'h00);
        wr(OFS_DATA, 32'h1FF);
        for (int i = 0; i < 8; i++) eng_pop_chk("R12 R2 tx order masked", 16'(i * 'h11));
        @(negedge clk);
        chk("R2 dropped write absent", {31'd0, tx_pop_valid}, 32'd0);
        rd_chk("R4 status drained", OFS_STATUS, 32'h03);
    endtask

    task automatic t_rx_path();
        wr(OFS_CTRL0, 32'hF);
        eng_push(16'hFFFF);
        rd_chk("R4 status rx one", OFS_STATUS, 32'h07);
        rd_chk("R3 pop full width", OFS_DATA, 32'hFFFF);
        wr(OFS_CTRL0, 32'h3);
        eng_push(16'h1234);
        rd_chk("R7 R11 four bit mask", OFS_DATA, 32'h4);
        wr(OFS_CTRL0, 32'hF);
        for (int i = 0; i < 8; i++) eng_push(16'hA000 + 16'(i));
        rd_chk("R4 status rx full", OFS_STATUS, 32'h0F);
        rd_chk("R5 raw both", OFS_RAW, 32'h0C);
        @(negedge clk);
        chk("R11 ready low when full", {31'd0, rx_push_ready}, 32'd0);
        eng_push(16'hBEEF);
        for (int i = 0; i < 8; i++) rd_chk("R12 R3 rx order", OFS_DATA, 32'hA000 + 32'(i));
        rd_chk("R3 empty read zero", OFS_DATA, 32'h0);
        rd_chk("R3 status after empty read", OFS_STATUS, 32'h03);
    endtask

    task automatic t_irq();
        wr(OFS_MASK, 32'h8);
        @(negedge clk);
        chk("R6 irq tx level", {31'd0, irq_o}, 32'd1);
        rd_chk("R6 masked tx", OFS_MASKED, 32'h08);
        for (int i = 0; i < 5; i++) wr(OFS_DATA, 32'h50 + i);
        rd_chk("R5 raw tx five", OFS_RAW, 32'h00);
        chk("R6 irq low", {31'd0, irq_o}, 32'd0);
        wr(OFS_MASK, 32'h4);
        rd_chk("R6 mask readback", OFS_MASK, 32'h4);
        for (int i = 0; i < 4; i++) eng_push(16'h60 + 16'(i));
        rd_chk("R5 raw rx four", OFS_RAW, 32'h04);
        rd_chk("R6 masked rx", OFS_MASKED, 32'h04);
        chk("R6 irq rx level", {31'd0, irq_o}, 32'd1);
        rd_chk("R3 pop first rx", OFS_DATA, 32'h60);
        @(negedge clk);
        chk("R5 irq below rx level", {31'd0, irq_o}, 32'd0);
        for (int i = 1; i < 4; i++) rd_chk("R3 drain rx", OFS_DATA, 32'h60 + 32'(i));
        for (int i = 0; i < 5; i++) eng_pop_chk("R10 drain tx", 16'h50 + 16'(i));
        wr(OFS_MASK, 32'h0);
    endtask

    task automatic t_misc();
        logic [7:0] ids [8] = '{8'h5A, 8'h3C, 8'h81, 8'h07, 8'hE4, 8'h19, 8'hC2, 8'h6B};
        wr(OFS_DIV, 32'h1234);
        rd_chk("R8 divider low byte", OFS_DIV, 32'h34);
        wr(OFS_DMA, 32'h1);
        rd_chk("R8 dma zero", OFS_DMA, 32'h0);
        rd_chk("R8 undefined zero", 12'h024, 32'h0);
        wr(OFS_CTRL0, 32'hFABCD);
        rd_chk("R7 ctrl0 readback", OFS_CTRL0, 32'hABCD);
        wr(OFS_CTRL1, 32'hFF);
        rd_chk("R7 ctrl1 readback", OFS_CTRL1, 32'hF);
        for (int i = 0; i < 8; i++) rd_chk("R9 id byte", 12'hFE0 + 12'(i * 4), {24'd0, ids[i]});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_tx_path();
        t_rx_path();
        t_irq();
        t_misc();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule